// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the bus timing unit of an 8-bit processor whose low address byte and data byte share one set of pins. The core hands it one machine cycle at a time. A cycle is one of five kinds: opcode fetch, memory read, memory write, I/O read or I/O write. Each request carries a 16-bit address, a write byte and a flag that marks the last cycle of an instruction. The sequencer then steps through the bus states. T1 puts the address on the pins and pulses the latch strobe. T2 and T3 transfer the data. T4 is a quiet decode state that only opcode fetches use.

A slow device holds READY low to stretch the transfer with wait states. Read data returns to the core with a one-clock done pulse. An external master can ask for the bus on `hold`. The request is granted only between instructions. While the bus is granted, the sequencer releases its address, data and control pins and raises `holdAck`.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the sequencer is idle and can accept a request. `rdN` and `wrN` are high, while `ale`, `busAdOe`, `holdAck`, `done`, `ioM`, `s1` and `s0` are low, and `busOe` is high.
- R2: The first state after a request is accepted is T1, which lasts one clock. In T1 `ale` is high and `busHighAddr` shows address bits 15:8. `busAdOut` shows address bits 7:0 with `busAdOe` high. `ale` is low in every other state.
- R3: The kind codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read and 4 I/O write. From T1 to the end of the cycle, `ioM` is 1 for kinds 3 and 4 and 0 otherwise. {`s1`,`s0`} is 11 for fetch, 10 for the other reads and 01 for writes. Both `ioM` and {`s1`,`s0`} are 0 when idle.
- R4: In a read cycle, `rdN` is low in T2, in each wait state and in T3, and `busAdOe` is low in those states.
- R5: In a write cycle, `busAdOut` carries the write byte with `busAdOe` high in T2, in each wait state and in T3, and `wrN` is low in those states.
- R6: `ready` is sampled at the end of T2 and at the end of each wait state. A low sample adds one wait state whose pin values equal those of T2. A non-fetch cycle therefore takes 3 clocks plus its wait states, and a fetch takes 4 clocks plus its wait states.
- R7: Read data is captured from `busAdIn` only at the end of T3. `done` is high for exactly the one clock after T3, and during that clock `rdData` holds the captured byte. Bus values seen in T2 or in wait states are not taken.
- R8: An opcode fetch adds a T4 state after T3. In T4 `rdN` and `wrN` are high, `ale` is low and `busAdOe` is low.
- R9: A request presented in the final state of a cycle (T3 for non-fetch cycles, T4 for fetches) is accepted there, and its T1 follows on the next clock.
- R10: If `hold` is high while idle or in a final state, and the last completed or completing cycle closed an instruction, the bus is granted. From the next clock `holdAck` is high, `busOe` and `busAdOe` are low, `reqReady` is low and requests are ignored. One clock after `hold` falls, the sequencer is idle again with `busOe` high.
- R11: A `hold` that arrives during an instruction is deferred. Cycles whose flag does not mark an instruction end complete normally and accept the following request. The bus is granted only after the cycle that marks the instruction end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request to run a machine cycle |
| reqKind | input | 3 | Cycle kind code |
| reqAddr | input | 16 | Cycle address |
| reqWdata | input | 8 | Byte to write |
| reqLast | input | 1 | This cycle ends an instruction |
| reqReady | output | 1 | Request is accepted on this clock edge if valid |
| rdData | output | 8 | Captured read byte |
| done | output | 1 | One-clock pulse after T3 |
| busHighAddr | output | 8 | High address byte pins |
| busAdOut | output | 8 | Shared address/data pins, output value |
| busAdIn | input | 8 | Shared address/data pins, input value |
| busAdOe | output | 1 | Drive enable for the shared pins |
| busOe | output | 1 | Drive enable for high address and control pins |
| ale | output | 1 | Address latch strobe |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| ioM | output | 1 | 1 for I/O space, 0 for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| ready | input | 1 | Device ready; low adds wait states |
| hold | input | 1 | External master requests the bus |
| holdAck | output | 1 | Bus granted to external master |

## Verification
A wrong state shows at the pins within one clock. The strobes and the drive enable are decoded straight from the state, so a state entered too early or skipped moves `ale`, `rdN`, `wrN` or `busAdOe` in that same clock. A wrongly held cycle kind or address appears as a wrong status code or address already in T1. A read captured in the wrong state returns the bus value meant to be ignored, and that shows at the following `done`. A wrong instruction-boundary flag becomes visible only at the next `hold`, through a grant that comes one instruction too early or too late.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

  typedef enum logic [2:0] {
    KIND_FETCH = 3'd0,
    KIND_MEMRD = 3'd1,
    KIND_MEMWR = 3'd2,
    KIND_IORD  = 3'd3,
    KIND_IOWR  = 3'd4
  } cycKind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5,
    ST_HELD = 3'd6
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;     // latch a new request
    logic capture;     // end of T3: take read byte, raise done
    logic phaseAddr;   // T1
    logic phaseXfer;   // T2, wait, T3
    logic active;      // T1..T4
    logic floatBus;    // bus granted away
  } strobes_t;

  function automatic logic kindIsRead(input logic [2:0] k);
    return (k == KIND_FETCH) || (k == KIND_MEMRD) || (k == KIND_IORD);
  endfunction

  function automatic logic kindIsWrite(input logic [2:0] k);
    return (k == KIND_MEMWR) || (k == KIND_IOWR);
  endfunction

  function automatic logic kindIsIo(input logic [2:0] k);
    return (k == KIND_IORD) || (k == KIND_IOWR);
  endfunction

  function automatic logic [1:0] kindStatus(input logic [2:0] k);
    if (k == KIND_FETCH) return 2'b11;
    if (kindIsRead(k))   return 2'b10;
    if (kindIsWrite(k))  return 2'b01;
    return 2'b00;
  endfunction

endpackage

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mux_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  input  logic       reqLast,
  input  logic       ready,
  input  logic       hold,
  output logic       reqReady,
  output logic       holdAck,
  output strobes_t   strb
);

  seqState_e stQ, stD;
  logic curFetchQ, curLastQ, atBoundaryQ;
  logic endState, boundaryNow, grantHold, accept;

  assign endState    = ((stQ == ST_T3) && !curFetchQ) || (stQ == ST_T4);
  assign boundaryNow = (stQ == ST_IDLE) ? atBoundaryQ : curLastQ;
  assign grantHold   = hold && ((stQ == ST_IDLE) || endState) && boundaryNow;
  assign reqReady    = ((stQ == ST_IDLE) || endState) && !grantHold;
  assign accept      = reqReady && reqValid;

  always_comb begin
    stD = stQ;
    unique case (stQ)
      ST_IDLE: begin
        if (grantHold)   stD = ST_HELD;
        else if (accept) stD = ST_T1;
      end
      ST_T1: stD = ST_T2;
      ST_T2, ST_TW: stD = ready ? ST_T3 : ST_TW;
      ST_T3, ST_T4: begin
        if (stQ == ST_T3 && curFetchQ) stD = ST_T4;
        else if (grantHold)            stD = ST_HELD;
        else if (accept)               stD = ST_T1;
        else                           stD = ST_IDLE;
      end
      ST_HELD: if (!hold) stD = ST_IDLE;
      default: stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ         <= ST_IDLE;
      curFetchQ   <= 1'b0;
      curLastQ    <= 1'b1;
      atBoundaryQ <= 1'b1;
    end else begin
      stQ <= stD;
      if (endState) atBoundaryQ <= curLastQ;
      if (accept) begin
        curFetchQ <= (reqKind == KIND_FETCH);
        curLastQ  <= reqLast;
      end
    end
  end

  assign holdAck        = (stQ == ST_HELD);
  assign strb.loadReq   = accept;
  assign strb.capture   = (stQ == ST_T3);
  assign strb.phaseAddr = (stQ == ST_T1);
  assign strb.phaseXfer = (stQ == ST_T2) || (stQ == ST_TW) || (stQ == ST_T3);
  assign strb.active    = (stQ == ST_T1) || strb.phaseXfer || (stQ == ST_T4);
  assign strb.floatBus  = (stQ == ST_HELD);

endmodule

// File: rtl/mux_bus_dp.sv
module mux_bus_dp
  import mux_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busAdIn,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic [ADDR_W-DATA_W-1:0] busHighAddr,
  output logic [DATA_W-1:0] busAdOut,
  output logic              busAdOe,
  output logic              busOe,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              ioM,
  output logic              s1,
  output logic              s0
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdDataQ;
  logic [2:0]        kindQ;
  logic              doneQ;
  logic              isRd, isWr;
  logic [1:0]        stat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      kindQ   <= KIND_FETCH;
      rdDataQ <= '0;
      doneQ   <= 1'b0;
    end else begin
      if (strb.loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        kindQ  <= reqKind;
      end
      doneQ <= strb.capture;
      if (strb.capture && kindIsRead(kindQ)) rdDataQ <= busAdIn;
    end
  end

  assign isRd = kindIsRead(kindQ);
  assign isWr = kindIsWrite(kindQ);
  assign stat = strb.active ? kindStatus(kindQ) : 2'b00;

  assign rdData      = rdDataQ;
  assign done        = doneQ;
  assign busHighAddr = addrQ[ADDR_W-1:DATA_W];
  assign busAdOut    = strb.phaseAddr ? addrQ[DATA_W-1:0] : wdataQ;
  assign busAdOe     = strb.phaseAddr || (strb.phaseXfer && isWr);
  assign busOe       = !strb.floatBus;
  assign ale         = strb.phaseAddr;
  assign rdN         = !(strb.phaseXfer && isRd);
  assign wrN         = !(strb.phaseXfer && isWr);
  assign ioM         = strb.active && kindIsIo(kindQ);
  assign s1          = stat[1];
  assign s0          = stat[0];

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mux_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqLast,
  output logic              reqReady,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic [HI_W-1:0]   busHighAddr,
  output logic [DATA_W-1:0] busAdOut,
  input  logic [DATA_W-1:0] busAdIn,
  output logic              busAdOe,
  output logic              busOe,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              ioM,
  output logic              s1,
  output logic              s0,
  input  logic              ready,
  input  logic              hold,
  output logic              holdAck
);

  strobes_t strb;

  mux_bus_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .reqLast  (reqLast),
    .ready    (ready),
    .hold     (hold),
    .reqReady (reqReady),
    .holdAck  (holdAck),
    .strb     (strb)
  );

  mux_bus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqKind     (reqKind),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .busAdIn     (busAdIn),
    .rdData      (rdData),
    .done        (done),
    .busHighAddr (busHighAddr),
    .busAdOut    (busAdOut),
    .busAdOe     (busAdOe),
    .busOe       (busOe),
    .ale         (ale),
    .rdN         (rdN),
    .wrN         (wrN),
    .ioM         (ioM),
    .s1          (s1),
    .s0          (s0)
  );

endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk (
  input logic clk,
  input logic rstN,
  input logic ale,
  input logic rdN,
  input logic wrN,
  input logic busAdOe,
  input logic busOe,
  input logic ready,
  input logic done,
  input logic holdAck,
  input logic reqReady
);

  // R2
  ale_single_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  // R2
  ale_drives_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (busAdOe && busOe && rdN && wrN));

  // R4
  read_releases_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (!busAdOe && wrN));

  // R6
  wait_keeps_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && $past(ale) && !ready) |=> !rdN);

  // R7
  done_follows_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(!rdN || !wrN));

  // R10
  held_floats_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> (!busOe && !busAdOe && !ale && !reqReady));

endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ale      (ale),
  .rdN      (rdN),
  .wrN      (wrN),
  .busAdOe  (busAdOe),
  .busOe    (busOe),
  .ready    (ready),
  .done     (done),
  .holdAck  (holdAck),
  .reqReady (reqReady)
);

// File: tb/mux_bus_seq_tb.sv
module mux_bus_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = 3'd0;
  logic [15:0] reqAddr = 16'h0;
  logic [7:0]  reqWdata = 8'h0;
  logic        reqLast = 1'b0;
  logic        reqReady;
  logic [7:0]  rdData;
  logic        done;
  logic [7:0]  busHighAddr, busAdOut;
  logic [7:0]  busAdIn = 8'h00;
  logic        busAdOe, busOe, ale, rdN, wrN, ioM, s1, s0;
  logic        ready = 1'b1;
  logic        hold = 1'b0;
  logic        holdAck;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // expectations carried between cycles
  bit       expDone = 0;
  bit       expRd = 0;
  logic [7:0] expRdVal = 8'h0;
  bit       holdInT1 = 0;
  int       pKind = 0;
  logic [15:0] pAddr = 0;
  logic [7:0]  pWdata = 0;
  bit       pLast = 0;

  always #10 clk = ~clk;  // 50 MHz

  mux_bus_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqLast(reqLast),
    .reqReady(reqReady), .rdData(rdData), .done(done),
    .busHighAddr(busHighAddr), .busAdOut(busAdOut), .busAdIn(busAdIn),
    .busAdOe(busAdOe), .busOe(busOe), .ale(ale), .rdN(rdN), .wrN(wrN),
    .ioM(ioM), .s1(s1), .s0(s0), .ready(ready), .hold(hold),
    .holdAck(holdAck)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkDone();
    chk(done == expDone, "R7", "done", done, expDone);
    if (expDone && expRd) chk(rdData == expRdVal, "R7", "rdData", rdData, expRdVal);
    expDone = 0;
  endtask

  task automatic checkXfer(input bit isRd, input bit isWr, input logic [7:0] wd,
                           input string tag);
    chk(ale == 1'b0, "R2", {tag, " ale"}, ale, 0);
    if (isRd) begin
      chk(rdN == 1'b0 && wrN == 1'b1, "R4", {tag, " rdN/wrN"}, {rdN, wrN}, 2'b01);
      chk(busAdOe == 1'b0, "R4", {tag, " busAdOe"}, busAdOe, 0);
    end
    if (isWr) begin
      chk(wrN == 1'b0 && rdN == 1'b1, "R5", {tag, " rdN/wrN"}, {rdN, wrN}, 2'b10);
      chk(busAdOe && busAdOut == wd, "R5", {tag, " data"}, busAdOut, wd);
    end
  endtask

  // one machine cycle; slow device model supplies waits and read data
  task automatic runCycle(input int kind, input logic [15:0] addr,
                          input logic [7:0] wd, input bit last, input int waits,
                          input logic [7:0] rdVal, input bit issued,
                          input bit chainNext);
    bit isRd = (kind == 0) || (kind == 1) || (kind == 3);
    bit isWr = (kind == 2) || (kind == 4);
    bit isIo = (kind == 3) || (kind == 4);
    logic [1:0] st = (kind == 0) ? 2'b11 : (isRd ? 2'b10 : 2'b01);
    if (!issued) begin
      reqKind = 3'(kind); reqAddr = addr; reqWdata = wd; reqLast = last;
      reqValid = 1'b1;
      #1;
      chk(reqReady == 1'b1, "R1", "reqReady idle", reqReady, 1);
    end
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    // T1
    checkDone();
    if (holdInT1) begin hold = 1'b1; holdInT1 = 0; end
    chk(ale == 1'b1, "R2", "T1 ale", ale, 1);
    chk(busAdOe && busAdOut == addr[7:0], "R2", "T1 low addr", busAdOut, addr[7:0]);
    chk(busHighAddr == addr[15:8], "R2", "T1 high addr", busHighAddr, addr[15:8]);
    chk(ioM == isIo && {s1, s0} == st, "R3", "T1 ioM/status", {ioM, s1, s0}, {isIo, st});
    busAdIn = ~rdVal;
    // T2
    @(negedge clk);
    ready = (waits == 0);
    checkXfer(isRd, isWr, wd, "T2");
    chk(ioM == isIo && {s1, s0} == st, "R3", "T2 ioM/status", {ioM, s1, s0}, {isIo, st});
    for (int k = 0; k < waits; k++) begin
      @(negedge clk);
      ready = (k == waits - 1);
      checkXfer(isRd, isWr, wd, "R6 wait");
      chk(busHighAddr == addr[15:8], "R6", "wait high addr", busHighAddr, addr[15:8]);
    end
    // T3
    @(negedge clk);
    ready = 1'b1;
    busAdIn = rdVal;
    checkXfer(isRd, isWr, wd, "T3");
    expDone = 1; expRd = isRd; expRdVal = rdVal;
    if (kind == 0) begin
      @(negedge clk);  // T4
      busAdIn = ~rdVal;
      checkDone();
      chk(rdN && wrN && !ale && !busAdOe, "R8", "T4 quiet",
          {rdN, wrN, ale, busAdOe}, 4'b1100);
      chk({s1, s0} == 2'b11, "R3", "T4 status", {s1, s0}, 3);
    end
    if (chainNext) begin
      reqKind = 3'(pKind); reqAddr = pAddr; reqWdata = pWdata; reqLast = pLast;
      reqValid = 1'b1;
      #1;
      chk(reqReady == 1'b1, "R9", "accept in final state", reqReady, 1);
    end else begin
      #1;
      chk(reqReady == !(hold && last), "R11", "final reqReady", reqReady, !(hold && last));
      @(negedge clk);
      busAdIn = 8'h00;
      checkDone();
      chk(holdAck == (hold && last), "R10", "grant after cycle", holdAck, hold && last);
      chk(busOe == !(hold && last), "R10", "busOe after cycle", busOe, !(hold && last));
      if (!(hold && last))
        chk(rdN && wrN && !ale && !ioM && {s1, s0} == 2'b00, "R3", "idle pins",
            {rdN, wrN, ale, ioM, s1, s0}, 6'b110000);
    end
  endtask

  task automatic testReset();
    chk(rdN && wrN, "R1", "strobes", {rdN, wrN}, 2'b11);
    chk(!ale && !busAdOe && !holdAck && !done, "R1", "ale/oe/ack/done",
        {ale, busAdOe, holdAck, done}, 0);
    chk(busOe && reqReady, "R1", "busOe/reqReady", {busOe, reqReady}, 2'b11);
    chk({ioM, s1, s0} == 3'b000, "R1", "status", {ioM, s1, s0}, 0);
  endtask

  // OUT-style: opcode fetch, operand read, then I/O write
  task automatic testOutSequence();
    pKind = 1; pAddr = 16'h1235; pWdata = 8'h00; pLast = 0;
    runCycle(0, 16'h1234, 8'h00, 0, 0, 8'hD3, 0, 1);
    pKind = 4; pAddr = 16'h5A5A; pWdata = 8'h77; pLast = 1;
    runCycle(1, 16'h1235, 8'h00, 0, 2, 8'h5A, 1, 1);
    runCycle(4, 16'h5A5A, 8'h77, 1, 1, 8'h00, 1, 0);
  endtask

  task automatic testMemWrite();
    runCycle(2, 16'hBEEF, 8'hC4, 1, 0, 8'h00, 0, 0);
  endtask

  task automatic testIoReadSlow();
    runCycle(3, 16'h4040, 8'h00, 1, 3, 8'h9E, 0, 0);
  endtask

  task automatic testHoldAtBoundary();
    hold = 1'b1;
    reqKind = 3'd1; reqAddr = 16'h2222; reqLast = 1'b1; reqValid = 1'b1;
    #1;
    chk(reqReady == 1'b0, "R10", "reqReady under hold", reqReady, 0);
    @(negedge clk);
    chk(holdAck && !busOe && !busAdOe, "R10", "granted", {holdAck, busOe, busAdOe}, 3'b100);
    @(negedge clk);
    chk(holdAck && !ale && rdN, "R10", "request ignored", {holdAck, ale, rdN}, 3'b101);
    hold = 1'b0; reqValid = 1'b0;
    @(negedge clk);
    chk(!holdAck && busOe && reqReady, "R10", "released",
        {holdAck, busOe, reqReady}, 3'b011);
  endtask

  task automatic testHoldDeferred();
    holdInT1 = 1;
    pKind = 1; pAddr = 16'h0101; pWdata = 8'h00; pLast = 1;
    runCycle(0, 16'h0100, 8'h00, 0, 1, 8'h3E, 0, 1);   // R11: still accepts
    runCycle(1, 16'h0101, 8'h00, 1, 0, 8'h42, 1, 0);   // grant only now
    hold = 1'b0;
    @(negedge clk);
    chk(!holdAck && busOe, "R10", "released after deferred", {holdAck, busOe}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOutSequence();
    testMemWrite();
    testIoReadSlow();
    testHoldAtBoundary();
    testHoldDeferred();
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule